// File: doc/BRIEF.md
# Triangular-Carrier PWM Generator with Bootstrap Refresh

This block turns three per-phase modulation levels into six raw gate commands (one high-side and one low-side per phase) for a three-phase bridge. A symmetric triangular carrier is produced from the reference clock by an up/down counter. In sine mode each phase's high side conducts while its modulation level is above the carrier, and its low side conducts otherwise. In square-wave mode the Hall sensor state picks one conducting high side and one conducting low side, following the 120-degree commutation pattern. The amplitude code then sets the high-side on time.

In square-wave mode, and in either mode when the amplitude code is at or below a small idle threshold, a short low-side pulse recurs once per carrier period to keep the bootstrap capacitors charged. That pulse is centred on the carrier peak, and any high side that would overlap it is switched off. The commands come out of one register stage. Dead time and fault blanking are added downstream.

Top module: `tri_carrier_pwm`

## Requirements
- R1: The carrier counts 0,1,...,126 and then back down 125,...,1, so its period is 252 clocks. After reset it starts at 0 and rises. Each output register holds the result computed from the carrier value and the inputs present at the previous clock edge.
- R2: In sine mode with amp above 5, hi_cmd[i] is 1 exactly when the phase-i sample is strictly greater than the carrier, and lo_cmd[i] is its complement. No forced pulse is applied. The phase-i sample is mod_samples[7*i +: 7], with phase 0=U, 1=V, 2=W.
- R3: The refresh window covers 20 clocks of every carrier period: the last 10 rising steps before the peak, the peak itself, and the first 9 falling steps. Counted as carrier phase p = cycles since reset mod 252, this is p = 116..135.
- R4: When amp is 5 or less, every high side is off in both modes. In sine mode each low side is then on only inside the refresh window. An amp of 6 restores normal drive.
- R5: In square-wave mode every low side is on inside the refresh window, whatever the amplitude code.
- R6: In square-wave mode with reverse=0, hall={U,V,W} selects (high, low) as follows: 101 gives (U,V), 100 gives (U,W), 110 gives (V,W), 010 gives (V,U), 011 gives (W,U), 001 gives (W,V). The selected low side is on for the whole period.
- R7: With reverse=1 the selected high and low phases of R6 are swapped, which reverses the commutation sequence.
- R8: In square-wave mode the selected high side is on when amp is strictly greater than the carrier and the refresh window is inactive. amp=117 gives 232 of 252 clocks (92%).
- R9: Hall states 000 and 111 select no phase. Only the refresh pulses remain.
- R10: No phase ever has hi_cmd and lo_cmd high together.
- R11: While rst_n is low, all six commands are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sine_mode | input | 1 | 1: carrier comparison, 0: 120-degree square-wave drive |
| mod_samples | input | 21 | Three 7-bit modulation levels, phase i at bits 7*i +: 7 |
| hall | input | 3 | Hall state {U,V,W} |
| reverse | input | 1 | 1 swaps high and low selection |
| amp | input | 7 | Amplitude code in carrier units |
| hi_cmd | output | 3 | High-side commands, bit i = phase i |
| lo_cmd | output | 3 | Low-side commands, bit i = phase i |

## Verification
A carrier that skips, stalls or turns early shows up on the next clock in sine mode, as soon as any sample lies near the carrier. It also shifts the refresh pulse of idle phases within a single 252-clock period. A wrong Hall decode or direction swap shows on the clock after the Hall inputs change. A misplaced window or amplitude compare changes the per-period on-time counts, and the bench compares these cycle by cycle and as totals.

// File: rtl/tcp_pkg.sv
package tcp_pkg;
   localparam int NPH = 3;

   typedef struct packed {
      logic [NPH-1:0] hi;
      logic [NPH-1:0] lo;
   } leg_sel_t;

   // Hall state {U,V,W} to conducting pair; phase bit 0=U, 1=V, 2=W
   function automatic leg_sel_t hall_decode(input logic [2:0] h, input logic rev);
      leg_sel_t s;
      s = '0;
      case (h)
         3'b101: begin s.hi = 3'b001; s.lo = 3'b010; end
         3'b100: begin s.hi = 3'b001; s.lo = 3'b100; end
         3'b110: begin s.hi = 3'b010; s.lo = 3'b100; end
         3'b010: begin s.hi = 3'b010; s.lo = 3'b001; end
         3'b011: begin s.hi = 3'b100; s.lo = 3'b001; end
         3'b001: begin s.hi = 3'b100; s.lo = 3'b010; end
         default: s = '0;
      endcase
      if (rev) s = '{hi: s.lo, lo: s.hi};
      return s;
   endfunction
endpackage

// File: rtl/tcp_carrier.sv
module tcp_carrier #(
   parameter int HALF = 126,
   parameter int CW   = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [CW-1:0] level,
   output logic          rising
);
   localparam logic [CW-1:0] TOP_M1 = CW'(HALF - 1);
   localparam logic [CW-1:0] TOP    = CW'(HALF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level  <= '0;
         rising <= 1'b1;
      end else if (rising) begin
         level <= level + 1'b1;
         if (level == TOP_M1) rising <= 1'b0;
      end else begin
         level <= level - 1'b1;
         if (level == CW'(1)) rising <= 1'b1;
      end
   end

   assert_carrier_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      level <= TOP);
   assert_carrier_peak_turn_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (level == TOP) |=> (level == TOP_M1));
   assert_carrier_floor_turn_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (level == '0) |=> (level == CW'(1)));
endmodule

// File: rtl/tcp_refresh_window.sv
module tcp_refresh_window #(
   parameter int HALF  = 126,
   parameter int BOOST = 20,
   parameter int CW    = 7
) (
   input  logic [CW-1:0] level,
   input  logic          rising,
   output logic          win
);
   // rising side contributes BOOST/2 steps, falling side (peak included) the rest
   localparam int UP_START = HALF - BOOST / 2;
   localparam int DN_START = HALF - (BOOST - BOOST / 2) + 1;

   always_comb begin
      if (rising) win = (level >= CW'(UP_START));
      else        win = (level >= CW'(DN_START));
   end
endmodule

// File: rtl/tcp_commutator.sv
module tcp_commutator
   import tcp_pkg::*;
(
   input  logic           sine_mode,
   input  logic [2:0]     hall,
   input  logic           reverse,
   output logic [NPH-1:0] sel_hi,
   output logic [NPH-1:0] sel_lo
);
   leg_sel_t dec;

   always_comb begin
      dec = hall_decode(hall, reverse);
      if (sine_mode) begin
         sel_hi = '0;
         sel_lo = '0;
      end else begin
         sel_hi = dec.hi;
         sel_lo = dec.lo;
      end
   end
endmodule

// File: rtl/tcp_leg.sv
module tcp_leg #(
   parameter int CW       = 7,
   parameter int LOW_CODE = 5,
   parameter bit OUT_REG  = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sine_mode,
   input  logic [CW-1:0] sample,
   input  logic [CW-1:0] level,
   input  logic          win,
   input  logic [CW-1:0] amp,
   input  logic          sel_hi,
   input  logic          sel_lo,
   output logic          hi,
   output logic          lo
);
   logic above, amp_ok, hi_n, lo_n;

   assign above  = (sample > level);
   assign amp_ok = (amp > CW'(LOW_CODE));

   always_comb begin
      if (sine_mode) begin
         hi_n = amp_ok & above;
         lo_n = amp_ok ? ~above : win;
      end else begin
         hi_n = amp_ok & sel_hi & ~win & (amp > level);
         lo_n = win | sel_lo;
      end
   end

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hi <= 1'b0;
               lo <= 1'b0;
            end else begin
               hi <= hi_n;
               lo <= lo_n;
            end
         end

         assert_lowamp_hi_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (amp <= CW'(LOW_CODE)) |=> !hi);
         assert_square_refresh_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!sine_mode && win) |=> lo);
         assert_sine_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (sine_mode && amp_ok) |=> (hi == $past(above)));
      end else begin : g_comb
         assign hi = hi_n;
         assign lo = lo_n;
      end
   endgenerate

   assert_hi_lo_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi && lo));
endmodule

// File: rtl/tri_carrier_pwm.sv
module tri_carrier_pwm
   import tcp_pkg::*;
#(
   parameter int HALF     = 126,
   parameter int BOOST    = 20,
   parameter int LOW_CODE = 5,
   parameter bit OUT_REG  = 1'b1,
   localparam int CW      = $clog2(HALF + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sine_mode,
   input  logic [3*CW-1:0] mod_samples,
   input  logic [2:0]      hall,
   input  logic            reverse,
   input  logic [CW-1:0]   amp,
   output logic [2:0]      hi_cmd,
   output logic [2:0]      lo_cmd
);
   generate
      if (HALF < 4) begin : g_bad_half
         $error("HALF must be at least 4");
      end
      if (BOOST < 2 || BOOST >= HALF) begin : g_bad_boost
         $error("BOOST must lie in 2..HALF-1");
      end
      if (LOW_CODE >= HALF) begin : g_bad_low
         $error("LOW_CODE must be below HALF");
      end
   endgenerate

   logic [CW-1:0]  level;
   logic           rising;
   logic           win;
   logic [NPH-1:0] sel_hi, sel_lo;

   tcp_carrier #(.HALF(HALF), .CW(CW)) u_carrier (
      .clk(clk), .rst_n(rst_n), .level(level), .rising(rising));

   tcp_refresh_window #(.HALF(HALF), .BOOST(BOOST), .CW(CW)) u_window (
      .level(level), .rising(rising), .win(win));

   tcp_commutator u_comm (
      .sine_mode(sine_mode), .hall(hall), .reverse(reverse),
      .sel_hi(sel_hi), .sel_lo(sel_lo));

   for (genvar i = 0; i < NPH; i++) begin : g_leg
      tcp_leg #(.CW(CW), .LOW_CODE(LOW_CODE), .OUT_REG(OUT_REG)) u_leg (
         .clk(clk), .rst_n(rst_n), .sine_mode(sine_mode),
         .sample(mod_samples[CW*i +: CW]), .level(level), .win(win), .amp(amp),
         .sel_hi(sel_hi[i]), .sel_lo(sel_lo[i]),
         .hi(hi_cmd[i]), .lo(lo_cmd[i]));
   end

   assert_window_at_peak_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (level == CW'(HALF)) |-> win);
   assert_window_off_at_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (level == '0) |-> !win);
   assert_one_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_hi) && $onehot0(sel_lo) && ((sel_hi & sel_lo) == '0));
   assert_idle_hall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (hall == 3'b000 || hall == 3'b111) |-> (sel_hi == '0 && sel_lo == '0));
endmodule

// File: tb/tri_carrier_pwm_test.sv
`timescale 1ns/1ps
module tri_carrier_pwm_test;
   localparam int PER = 252;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sine_mode = 1'b1;
   logic [20:0] mod_samples = '0;
   logic [2:0]  hall = 3'b000;
   logic        reverse = 1'b0;
   logic [6:0]  amp = '0;
   logic [2:0]  hi_cmd, lo_cmd;

   int checks = 0;
   int bad = 0;
   int edges = 0;
   int hi_cnt[3];
   int lo_cnt[3];
   bit done = 0;

   always #2.5 clk = ~clk;

   tri_carrier_pwm uut (
      .clk(clk), .rst_n(rst_n), .sine_mode(sine_mode), .mod_samples(mod_samples),
      .hall(hall), .reverse(reverse), .amp(amp), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd));

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) edges <= 0;
      else        edges <= edges + 1;
   end

   function automatic void model(input int p, output logic [2:0] ehi, output logic [2:0] elo);
      int c, hp, lp, s;
      bit w, ok;
      c  = (p <= 126) ? p : PER - p;
      w  = (p >= 116) && (p <= 135);
      ok = (amp > 7'd5);
      hp = -1; lp = -1;
      case (hall)
         3'b101: begin hp = 0; lp = 1; end
         3'b100: begin hp = 0; lp = 2; end
         3'b110: begin hp = 1; lp = 2; end
         3'b010: begin hp = 1; lp = 0; end
         3'b011: begin hp = 2; lp = 0; end
         3'b001: begin hp = 2; lp = 1; end
         default: begin hp = -1; lp = -1; end
      endcase
      if (reverse) begin s = hp; hp = lp; lp = s; end
      for (int i = 0; i < 3; i++) begin
         s = int'(mod_samples[7*i +: 7]);
         if (sine_mode) begin
            ehi[i] = ok && (s > c);
            elo[i] = ok ? !(s > c) : w;
         end else begin
            ehi[i] = ok && (i == hp) && !w && (int'(amp) > c);
            elo[i] = w || (i == lp);
         end
      end
   endfunction

   task automatic run(input int n, input string tag);
      logic [2:0] ehi, elo;
      for (int k = 0; k < 3; k++) begin hi_cnt[k] = 0; lo_cnt[k] = 0; end
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         model((edges - 1) % PER, ehi, elo);
         checks++;
         if (hi_cmd !== ehi || lo_cmd !== elo) begin
            bad++;
            $display("FAIL %s phase=%0d hi=%b lo=%b expected hi=%b lo=%b",
                     tag, (edges - 1) % PER, hi_cmd, lo_cmd, ehi, elo);
         end
         checks++;
         if ((hi_cmd & lo_cmd) != 3'b000) begin
            bad++;
            $display("FAIL R10 overlap hi=%b lo=%b expected no common bit", hi_cmd, lo_cmd);
         end
         for (int j = 0; j < 3; j++) begin
            hi_cnt[j] += int'(hi_cmd[j]);
            lo_cnt[j] += int'(lo_cmd[j]);
         end
      end
   endtask

   task automatic expect_count(input int act, input int exp, input string tag);
      checks++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s count=%0d expected %0d", tag, act, exp);
      end
   endtask

   initial begin
      mod_samples = {7'd127, 7'd63, 7'd0};
      amp = 7'd100;
      repeat (3) @(negedge clk);
      checks++; // R11 reset state
      if (hi_cmd !== 3'b000 || lo_cmd !== 3'b000) begin
         bad++;
         $display("FAIL R11 hi=%b lo=%b expected 000/000", hi_cmd, lo_cmd);
      end
      rst_n = 1'b1;
      run(PER, "R1");
      mod_samples = {7'd100, 7'd1, 7'd126};
      run(PER, "R2");
      mod_samples = {7'd64, 7'd64, 7'd64};
      run(PER + 37, "R2");
      // R4 boundary: 5 idles, 6 drives
      amp = 7'd5;
      run(PER, "R4");
      amp = 7'd0;
      run(PER, "R3");
      for (int j = 0; j < 3; j++) begin
         expect_count(lo_cnt[j], 20, "R3 refresh width");
         expect_count(hi_cnt[j], 0, "R4 high sides idle");
      end
      amp = 7'd6;
      run(PER, "R4");
      // square-wave sweeps
      sine_mode = 1'b0;
      for (int d = 0; d < 2; d++) begin
         for (int h = 0; h < 8; h++) begin
            for (int a = 0; a < 4; a++) begin
               reverse = d[0];
               hall = 3'(h);
               amp = (a == 0) ? 7'd117 : (a == 1) ? 7'd127 : (a == 2) ? 7'd60 : 7'd3;
               if (h == 0 || h == 7) run(PER, "R9");
               else if (a == 3)      run(PER, "R5");
               else if (d == 1)      run(PER, "R7");
               else                  run(PER, "R6");
            end
         end
      end
      reverse = 1'b0;
      hall = 3'b101;
      amp = 7'd117;
      run(PER, "R8");
      expect_count(hi_cnt[0], 232, "R8 duty at 117");
      expect_count(lo_cnt[1], PER, "R6 selected low full");
      expect_count(lo_cnt[2], 20, "R5 refresh width");
      reverse = 1'b1;
      run(PER, "R7");
      expect_count(hi_cnt[1], 232, "R7 swapped high");
      expect_count(lo_cnt[0], PER, "R7 swapped low");
      done = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         checks++;
         bad++;
         $display("FAIL watchdog expired expected completion");
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end
endmodule